// File: doc/BRIEF.md
# Sequential Radix-8 Booth Significand Multiplier

This block multiplies two single-precision floating-point operands that have already been unpacked. Each operand arrives as a sign, an 8-bit biased exponent and a 24-bit significand with the leading one written out. A one-cycle `start` strobe loads the operands. The block then recodes the multiplier three bits at a time into signed digits from -4 to +4. It adds one multiple of the multiplicand per cycle into an accumulator that holds separate sum and carry vectors, so that no carry has to ripple during an iteration. Nine iteration cycles cover the 24-bit significand plus the extra zero bit that the recoding needs at the top.

Two fixed cycles follow the iterations. In the round cycle, one carry-propagate add resolves the sum and carry vectors into the 48-bit product. The same cycle picks the normalisation position and decides whether to round up. In the tidy cycle, the increment is applied, a carry out of the rounding is absorbed, and the exponent is fixed up. The result then appears with a one-cycle `done` pulse. The latency never depends on the operand values. The rounding mode is sampled with `start`: either round to nearest with ties to even, or round toward minus infinity.

The exponent output is 10 bits wide and uses two's complement, so the owner can detect overflow and underflow downstream. Denormal inputs, infinities and NaNs are not handled. A zero significand on either side is the only special case.

Top module: `booth8_sigmul`

## Requirements
- R1: After reset, `busy`, `done`, `p_sign`, `p_exp` and `p_sig` are all zero.
- R2: A `start` seen while idle is accepted. `busy` is then high, and `done` rises exactly 11 clock edges after the accepting edge and stays high for one cycle only. This timing is the same for every operand value.
- R3: With `round_down` = 0 the result significand is the exact 48-bit product rounded to 24 bits, to nearest, with ties going to the even value. Bit 23 of any nonzero `p_sig` is 1.
- R4: With `round_down` = 1 (sampled at start), a negative result whose discarded bits are not all zero grows by one unit in the last place. A positive result is truncated.
- R5: `p_sign` is the XOR of `a_sign` and `b_sign`, including for zero results.
- R6: `p_exp` = `a_exp` + `b_exp` − 127, plus 1 when the product significand is 2 or more, plus 1 more when rounding carries out of bit 23. It is taken modulo 2^10.
- R7: When rounding carries out of the significand, `p_sig` is 0x800000 and the exponent gains the extra 1 of R6.
- R8: If either input significand is zero, `p_sig` and `p_exp` are both zero.
- R9: A `start` raised while `busy` is high is ignored. The running result is unchanged, and no second `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load operands and begin (accepted only when idle) |
| round_down | input | 1 | 1: round toward minus infinity; 0: nearest-even |
| a_sign | input | 1 | Sign of multiplicand operand |
| a_exp | input | 8 | Biased exponent of operand A |
| a_sig | input | 24 | Significand of A, leading one explicit |
| b_sign | input | 1 | Sign of multiplier operand |
| b_exp | input | 8 | Biased exponent of operand B |
| b_sig | input | 24 | Significand of B, leading one explicit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, result valid |
| p_sign | output | 1 | Product sign |
| p_exp | output | 10 | Product exponent, biased, two's complement |
| p_sig | output | 24 | Rounded product significand |

## Verification
The bench sweeps every pair from a set of significands under both rounding modes, with mixed signs and exponents. The set holds 0x800000, 0xFFFFFF, alternating-bit patterns, near-tie values, zero and hashed values.

Each sweep result is compared with a model that rounds by comparing the remainder against half a unit. A Booth digit table with a wrong entry, or a dropped top digit, shows up as a wrong significand on most pairs.

Targeted cases cover exact ties in both directions, which catch rounding that always goes up. A negative product just below 2.0 carries out of the significand under round-down; a design without the carry fix-up would return 0x000000 or keep the old exponent. A second `start` fired mid-operation would corrupt the result or produce an extra `done` if it were not ignored.

// File: rtl/booth8_pkg.sv
package booth8_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_ITER, ST_ROUND, ST_TIDY} mul_state_t;

  // One radix-8 digit: sign plus magnitude 0..4
  typedef struct packed {
    logic       neg;
    logic [2:0] mag;
  } booth_dig_t;

  // Window bits [3:0] = y(3i+2), y(3i+1), y(3i), y(3i-1)
  function automatic booth_dig_t booth_recode(input logic [3:0] w);
    booth_dig_t r;
    int d;
    d = 2 * int'(w[2]) + int'(w[1]) + int'(w[0]) - 4 * int'(w[3]);
    r.neg = (d < 0);
    r.mag = 3'(d < 0 ? -d : d);
    return r;
  endfunction

endpackage

// File: rtl/booth8_pp_gen.sv
module booth8_pp_gen
  import booth8_pkg::*;
#(
  parameter int AW = 51
) (
  input  logic [3:0]    win,
  input  logic [AW-1:0] m1,
  input  logic [AW-1:0] m3,
  output logic [AW-1:0] pp
);

  booth_dig_t      dig;
  logic [AW-1:0]   mag_v;

  always_comb begin
    dig = booth_recode(win);
    case (dig.mag)
      3'd1:    mag_v = m1;
      3'd2:    mag_v = m1 << 1;
      3'd3:    mag_v = m3;
      3'd4:    mag_v = m1 << 2;
      default: mag_v = '0;
    endcase
    pp = dig.neg ? (~mag_v + AW'(1)) : mag_v;
  end

endmodule

// File: rtl/booth8_csa.sv
module booth8_csa #(
  parameter int AW = 51
) (
  input  logic [AW-1:0] s_in,
  input  logic [AW-1:0] c_in,
  input  logic [AW-1:0] pp,
  output logic [AW-1:0] s_out,
  output logic [AW-1:0] c_out
);

  assign s_out = s_in ^ c_in ^ pp;
  assign c_out = ((s_in & c_in) | (s_in & pp) | (c_in & pp)) << 1;

endmodule

// File: rtl/booth8_rounder.sv
module booth8_rounder #(
  parameter int MW = 24
) (
  input  logic [2*MW-1:0] prod,
  input  logic            neg,
  input  logic            mode_dn,
  output logic [MW-1:0]   kept,
  output logic            inc,
  output logic            norm
);

  logic guard, sticky;

  always_comb begin
    norm = prod[2*MW-1];
    if (norm) begin
      kept   = prod[2*MW-1:MW];
      guard  = prod[MW-1];
      sticky = |prod[MW-2:0];
    end else begin
      kept   = prod[2*MW-2:MW-1];
      guard  = prod[MW-2];
      sticky = |prod[MW-3:0];
    end
    if (mode_dn) inc = neg & (guard | sticky);
    else         inc = guard & (sticky | kept[0]);
  end

endmodule

// File: rtl/booth8_sigmul.sv
module booth8_sigmul
  import booth8_pkg::*;
#(
  parameter int MW   = 24,
  parameter int EW   = 8,
  parameter int BIAS = 127
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          round_down,
  input  logic          a_sign,
  input  logic [EW-1:0] a_exp,
  input  logic [MW-1:0] a_sig,
  input  logic          b_sign,
  input  logic [EW-1:0] b_exp,
  input  logic [MW-1:0] b_sig,
  output logic          busy,
  output logic          done,
  output logic          p_sign,
  output logic [EW+1:0] p_exp,
  output logic [MW-1:0] p_sig
);

  localparam int PW    = 2 * MW;
  localparam int STEPS = (MW + 3) / 3;
  localparam int YW    = 3 * STEPS;
  localparam int AW    = PW + 3;
  localparam int XW    = EW + 2;
  localparam int CW    = $clog2(STEPS + 1);

  mul_state_t    state;
  logic [CW-1:0] cnt;
  logic [YW:0]   mreg;
  logic [AW-1:0] m1_q, m3_q, sum_q, car_q;
  logic [AW-1:0] pp_w, s_nx, c_nx, prod_w;
  logic [MW-1:0] kept_w, kept_q;
  logic          inc_w, norm_w, inc_q, norm_q;
  logic          sign_q, mode_q, zero_q, done_q;
  logic [XW-1:0] exp_q;
  logic [MW:0]   rsum;
  logic          rnd_ovf;

  // named events for the checks
  logic accept_ev, last_iter, round_ev;
  assign accept_ev = (state == ST_IDLE) && start;
  assign last_iter = (state == ST_ITER) && (cnt == CW'(STEPS - 1));
  assign round_ev  = (state == ST_ROUND);

  booth8_pp_gen #(.AW(AW)) u_pp (
    .win(mreg[3:0]), .m1(m1_q), .m3(m3_q), .pp(pp_w)
  );

  booth8_csa #(.AW(AW)) u_csa (
    .s_in(sum_q), .c_in(car_q), .pp(pp_w), .s_out(s_nx), .c_out(c_nx)
  );

  assign prod_w = sum_q + car_q;

  booth8_rounder #(.MW(MW)) u_rnd (
    .prod(prod_w[PW-1:0]), .neg(sign_q), .mode_dn(mode_q),
    .kept(kept_w), .inc(inc_w), .norm(norm_w)
  );

  assign rsum    = {1'b0, kept_q} + (MW+1)'(inc_q);
  assign rnd_ovf = rsum[MW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      mreg   <= '0;
      m1_q   <= '0;
      m3_q   <= '0;
      sum_q  <= '0;
      car_q  <= '0;
      kept_q <= '0;
      inc_q  <= 1'b0;
      norm_q <= 1'b0;
      sign_q <= 1'b0;
      mode_q <= 1'b0;
      zero_q <= 1'b0;
      exp_q  <= '0;
      done_q <= 1'b0;
      p_sign <= 1'b0;
      p_exp  <= '0;
      p_sig  <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_ITER;
          cnt    <= '0;
          mreg   <= {{(YW-MW){1'b0}}, b_sig, 1'b0};
          m1_q   <= AW'(a_sig);
          m3_q   <= AW'(a_sig) + (AW'(a_sig) << 1);
          sum_q  <= '0;
          car_q  <= '0;
          sign_q <= a_sign ^ b_sign;
          mode_q <= round_down;
          zero_q <= (a_sig == '0) || (b_sig == '0);
          exp_q  <= XW'(a_exp) + XW'(b_exp) - XW'(BIAS);
        end
        ST_ITER: begin
          sum_q <= s_nx;
          car_q <= c_nx;
          mreg  <= mreg >> 3;
          m1_q  <= m1_q << 3;
          m3_q  <= m3_q << 3;
          cnt   <= cnt + CW'(1);
          if (last_iter) state <= ST_ROUND;
        end
        ST_ROUND: begin
          kept_q <= kept_w;
          inc_q  <= inc_w;
          norm_q <= norm_w;
          state  <= ST_TIDY;
        end
        default: begin
          p_sign <= sign_q;
          p_sig  <= zero_q ? '0 :
                    (rnd_ovf ? {1'b1, {(MW-1){1'b0}}} : rsum[MW-1:0]);
          p_exp  <= zero_q ? '0 : exp_q + XW'(norm_q) + XW'(rnd_ovf);
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = done_q;

  // R2: done is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R2: an accepted start always enters the iteration phase
  p_accept_iter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> (state == ST_ITER) && (cnt == '0));

  // R2: rounding only follows the final iteration step
  p_round_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    round_ev |-> $past(last_iter));

  // R3: the resolved accumulator never exceeds the product width
  p_prod_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    round_ev |-> (prod_w[AW-1:PW] == '0));

  // R3: nonzero results leave normalised
  p_norm_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (p_sig[MW-1] || zero_q));

  // R8: zero operand forces a zero significand and exponent
  p_zero_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && zero_q) |-> (p_sig == '0) && (p_exp == '0));

  // R9: captured operand data holds while an operation runs
  p_hold_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(exp_q) && $stable(sign_q) && $stable(mode_q) && $stable(zero_q));

endmodule

// File: tb/booth8_sigmul_test.sv
module booth8_sigmul_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        round_down = 1'b0;
  logic        a_sign = 1'b0, b_sign = 1'b0;
  logic [7:0]  a_exp = '0, b_exp = '0;
  logic [23:0] a_sig = '0, b_sig = '0;
  logic        busy, done, p_sign;
  logic [9:0]  p_exp;
  logic [23:0] p_sig;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  booth8_sigmul uut (
    .clk(clk), .rst_n(rst_n), .start(start), .round_down(round_down),
    .a_sign(a_sign), .a_exp(a_exp), .a_sig(a_sig),
    .b_sign(b_sign), .b_exp(b_exp), .b_sig(b_sig),
    .busy(busy), .done(done), .p_sign(p_sign), .p_exp(p_exp), .p_sig(p_sig)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog R2: actual hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  // Reference: remainder compared against half a unit
  function automatic void model(input bit sa, input bit sb, input int ea, input int eb,
                                input longint ma, input longint mb, input bit dn,
                                output bit es, output int ee, output longint em);
    longint p, q, rem, half;
    int k;
    bit up;
    es = sa ^ sb;
    if (ma == 0 || mb == 0) begin
      ee = 0; em = 0; return;
    end
    p = ma * mb;
    k = (p >= (64'sd1 <<< 47)) ? 24 : 23;
    q = p >>> k;
    rem = p - (q <<< k);
    half = 64'sd1 <<< (k - 1);
    if (dn) up = es && (rem != 0);
    else    up = (rem > half) || (rem == half && q[0]);
    q = q + longint'(up);
    ee = ea + eb - 127 + (k == 24 ? 1 : 0);
    if (q == (64'sd1 <<< 24)) begin
      q = 64'sd1 <<< 23; ee = ee + 1;
    end
    ee = ee & 10'h3FF;
    em = q;
  endfunction

  task automatic launch(input bit sa, input int ea, input logic [23:0] ma,
                        input bit sb, input int eb, input logic [23:0] mb, input bit dn);
    @(negedge clk);
    a_sign = sa; a_exp = 8'(ea); a_sig = ma;
    b_sign = sb; b_exp = 8'(eb); b_sig = mb;
    round_down = dn; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Runs one op, verifies latency, result against model
  task automatic run_op(input bit sa, input int ea, input logic [23:0] ma,
                        input bit sb, input int eb, input logic [23:0] mb,
                        input bit dn, input bit poke);
    bit es; int ee; longint em; string rq;
    bit lat_ok;
    model(sa, sb, ea, eb, longint'(ma), longint'(mb), dn, es, ee, em);
    launch(sa, ea, ma, sb, eb, mb, dn);
    lat_ok = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      if (poke && k == 4) begin
        a_sig = 24'h123456; b_sig = 24'hABCDEF; a_exp = 8'd3;
        a_sign = ~sa; round_down = ~dn; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      if (done || !busy) lat_ok = 1'b0;
    end
    @(negedge clk);
    if (!done) lat_ok = 1'b0;
    chk(lat_ok, "R2 latency", longint'(done), 1);
    rq = (ma == 0 || mb == 0) ? "R8" : (dn ? "R4" : "R3");
    chk(p_sig == 24'(em), {rq, " significand"}, longint'(p_sig), em);
    chk(p_sign == es, "R5 sign", longint'(p_sign), longint'(es));
    chk(int'(p_exp) == ee, "R6 exponent", longint'(p_exp), longint'(ee));
    if (poke) begin
      @(negedge clk);
      chk(!done && !busy, "R9 no second op", longint'({done, busy}), 0);
      @(negedge clk);
      chk(!done && !busy, "R9 still idle", longint'({done, busy}), 0);
    end
  endtask

  function automatic logic [23:0] pick(input int i);
    logic [31:0] h;
    case (i)
      0: return 24'h800000;
      1: return 24'hFFFFFF;
      2: return 24'h800001;
      3: return 24'hC00000;
      4: return 24'hAAAAAA;
      5: return 24'hD55555;
      6: return 24'h800003;
      7: return 24'hFFFFFE;
      8: return 24'h000000;
      9: return 24'hB504F3;
      10: return 24'h999999;
      11: return 24'hC00001;
      default: begin
        h = 32'(i) * 32'h9E3779B1;
        h = h ^ (h >> 13);
        return {1'b1, h[22:0]};
      end
    endcase
  endfunction

  initial begin
    // R1: reset state
    #5;
    chk(!busy && !done, "R1 idle flags", longint'({busy, done}), 0);
    chk(p_sig == 0 && p_exp == 0 && !p_sign, "R1 result regs", longint'(p_sig), 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1 after release", longint'({busy, done}), 0);

    // R3: tie rounds up to even
    run_op(1'b0, 127, 24'hC00000, 1'b0, 127, 24'h800001, 1'b0, 1'b0);
    chk(p_sig == 24'hC00002, "R3 tie to even up", longint'(p_sig), 24'hC00002);
    // R3: tie stays on even
    run_op(1'b0, 127, 24'hC00000, 1'b0, 127, 24'h800003, 1'b0, 1'b0);
    chk(p_sig == 24'hC00004, "R3 tie stays even", longint'(p_sig), 24'hC00004);
    // R7: negative, round down, carry out of significand
    run_op(1'b1, 127, 24'hB504F3, 1'b0, 127, 24'hB504F3, 1'b1, 1'b0);
    chk(p_sig == 24'h800000 && p_exp == 10'd128, "R7 carry out",
        longint'({p_exp, p_sig}), longint'({10'd128, 24'h800000}));
    // R4: positive, round down truncates
    run_op(1'b0, 127, 24'hB504F3, 1'b0, 127, 24'hB504F3, 1'b1, 1'b0);
    chk(p_sig == 24'hFFFFFF && p_exp == 10'd127, "R4 positive truncates",
        longint'({p_exp, p_sig}), longint'({10'd127, 24'hFFFFFF}));
    // R8: zero operand, negative sign
    run_op(1'b1, 200, 24'h000000, 1'b0, 90, 24'hABCDEF, 1'b0, 1'b0);
    chk(p_sig == 0 && p_exp == 0 && p_sign, "R8 zero result",
        longint'({p_sign, p_exp, p_sig}), longint'({1'b1, 34'd0}));
    // R9: start pulse during an op is ignored
    run_op(1'b1, 100, 24'hAAAAAA, 1'b1, 140, 24'hD55555, 1'b0, 1'b1);
    run_op(1'b0, 5, 24'hFFFFFF, 1'b1, 7, 24'hFFFFFF, 1'b1, 1'b1);

    // Sweep all pairs, both modes
    for (int i = 0; i < 24; i++) begin
      for (int j = 0; j < 24; j++) begin
        for (int m = 0; m < 2; m++) begin
          run_op(bit'((i + j) % 3 == 0), (i * 29 + j * 13 + 60) % 256, pick(i),
                 bit'(j[0] ^ m[0]), (j * 41 + i * 7 + 70) % 256, pick(j),
                 bit'(m), 1'b0);
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule